// File: doc/BRIEF.md
# Video Register Command Stream Decoder

This block sits behind a host byte channel and turns a stream of escape-prefixed commands into settings for a video timing controller. Each command opens with the escape byte 0xAF followed by an operation byte. A register-write command carries one address byte and one data byte. The decoder applies each write to a bank of 8-bit configuration registers.

The bank is double-buffered. While the host holds the bank locked, writes land only in a shadow copy, and the live outputs stay steady. Releasing the lock moves the whole shadow copy into the live copy in a single cycle and flags the change with a one-cycle strobe. While the bank is unlocked, writes reach both copies at once.

The live bank is presented both as a flat vector and as assembled fields: colour depth, blank mode, two 24-bit frame base addresses and three 16-bit timing values. The 16-bit fields do not all use the same byte order. The decoder also recognises a 9-byte rectangle-copy command and reports its fields on a separate output, but it does not carry out the copy. Malformed input is dropped, a sticky error flag is raised, and the parser hunts for the next escape byte.

Top module: `vidcmd_top`

## Requirements
- R1: After reset every live register reads 0x00, the bank is unlocked, and `err_o`, `commit_o` and `copy_valid_o` are low.
- R2: The 4-byte sequence 0xAF, 0x20, A, D writes D to register A. While unlocked, the new value is visible on the live outputs two clock edges after the data byte is accepted.
- R3: Writing 0x00 to register 0xFF locks the bank (`locked_o` goes high). Later writes then leave every live output unchanged.
- R4: Writing 0xFF to register 0xFF unlocks the bank. This copies the whole shadow bank to the live bank in one cycle and pulses `commit_o` high for exactly one cycle.
- R5: `base16_o` is {reg 0x20, reg 0x21, reg 0x22} and `base8_o` is {reg 0x26, reg 0x27, reg 0x28}, with the lowest address as the most significant byte.
- R6: `hpix_o` is {reg 0x0F, reg 0x10} and `vpix_o` is {reg 0x17, reg 0x18}, high byte at the lower address. `pclk_o` is {reg 0x1C, reg 0x1B}, low byte at the lower address.
- R7: `depth_o` reflects register 0x00, where 0 selects 16 bits per pixel. `blank_o` reflects register 0x1F.
- R8: The 9-byte sequence 0xAF, 0x6A, S2, S1, S0, N, D2, D1, D0 pulses `copy_valid_o` for one cycle with `copy_src_o`={S2,S1,S0}, `copy_len_o`=N and `copy_dst_o`={D2,D1,D0}. It changes no register.
- R9: An 0xAF received while an operation byte is awaited simply re-arms the parser. A lone trailing 0xAF therefore raises no error, and the next command decodes normally.
- R10: A byte other than 0xAF while idle, or an unknown operation byte, is dropped and sets `err_o`. `err_o` stays high until reset, and the parser resynchronises on the next 0xAF.
- R11: A write to an address at or above NUM_REGS, other than 0xFF, changes no live register.
- R12: `in_ready_o` is high at all times, so one byte is taken on each cycle that `in_valid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Byte accepted when valid |
| live_o | output | NUM_REGS*8 | Flat live bank, register i at bits [8i+7:8i] |
| depth_o | output | 8 | Colour depth selection |
| blank_o | output | 8 | Blank mode |
| base16_o | output | 24 | 16-bpp frame base address |
| base8_o | output | 24 | 8-bpp frame base address |
| hpix_o | output | 16 | Active pixels per line |
| vpix_o | output | 16 | Active lines |
| pclk_o | output | 16 | Pixel clock value |
| locked_o | output | 1 | Bank locked |
| commit_o | output | 1 | One-cycle pulse when the shadow bank goes live |
| copy_valid_o | output | 1 | Copy command decoded |
| copy_src_o | output | 24 | Copy source address |
| copy_len_o | output | 8 | Copy pixel count |
| copy_dst_o | output | 24 | Copy destination address |
| err_o | output | 1 | Sticky framing error |

## Verification
The bench builds the block with the default NUM_REGS of 48. This covers every assembled field up to address 0x28 and leaves addresses 0x30 and above outside the bank, which makes the out-of-range write case reachable. Commit and copy events are predicted into a scoreboard queue and matched as they appear, so a strobe that lasts too long or is missing is detected. A second reset in the middle of the run gives a clean error flag for the stray-byte case.

// File: rtl/vidcmd_pkg.sv
package vidcmd_pkg;
  localparam logic [7:0] ESC_BYTE   = 8'hAF;
  localparam logic [7:0] OPC_WRITE  = 8'h20;
  localparam logic [7:0] OPC_COPY   = 8'h6A;
  localparam logic [7:0] LOCK_REG   = 8'hFF;
  localparam logic [7:0] LOCK_ON    = 8'h00;
  localparam logic [7:0] LOCK_OFF   = 8'hFF;
  localparam int         REG_DEPTH  = 8'h00;
  localparam int         REG_HPIX   = 8'h0F;
  localparam int         REG_VPIX   = 8'h17;
  localparam int         REG_PCLK   = 8'h1B;
  localparam int         REG_BLANK  = 8'h1F;
  localparam int         REG_BASE16 = 8'h20;
  localparam int         REG_BASE8  = 8'h26;
  localparam int         COPY_ARGS  = 7;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_OPC,
    PS_ADDR,
    PS_DATA,
    PS_ARGS
  } pstate_e;
endpackage

// File: rtl/vidcmd_parser.sv
module vidcmd_parser
  import vidcmd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic [7:0]  in_data_i,
  output logic        wr_v_o,
  output logic [7:0]  wr_addr_o,
  output logic [7:0]  wr_data_o,
  output logic        copy_v_o,
  output logic [23:0] copy_src_o,
  output logic [7:0]  copy_len_o,
  output logic [23:0] copy_dst_o,
  output logic        err_o
);
  localparam int ARG_BYTES = COPY_ARGS - 1;
  localparam int CNT_W     = $clog2(COPY_ARGS);

  pstate_e              state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [8*ARG_BYTES-1:0] arg_q;
  logic [7:0]           addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= PS_IDLE;
      cnt_q      <= '0;
      arg_q      <= '0;
      addr_q     <= '0;
      wr_v_o     <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      copy_v_o   <= 1'b0;
      copy_src_o <= '0;
      copy_len_o <= '0;
      copy_dst_o <= '0;
      err_o      <= 1'b0;
    end else begin
      wr_v_o   <= 1'b0;
      copy_v_o <= 1'b0;
      if (in_valid_i) begin
        unique case (state_q)
          PS_IDLE: begin
            if (in_data_i == ESC_BYTE) state_q <= PS_OPC;
            else                       err_o   <= 1'b1;
          end
          PS_OPC: begin
            if (in_data_i == ESC_BYTE) begin
              state_q <= PS_OPC;  // re-arm: trailing escape is harmless
            end else if (in_data_i == OPC_WRITE) begin
              state_q <= PS_ADDR;
            end else if (in_data_i == OPC_COPY) begin
              state_q <= PS_ARGS;
              cnt_q   <= '0;
            end else begin
              state_q <= PS_IDLE;
              err_o   <= 1'b1;
            end
          end
          PS_ADDR: begin
            addr_q  <= in_data_i;
            state_q <= PS_DATA;
          end
          PS_DATA: begin
            wr_v_o    <= 1'b1;
            wr_addr_o <= addr_q;
            wr_data_o <= in_data_i;
            state_q   <= PS_IDLE;
          end
          PS_ARGS: begin
            if (cnt_q == CNT_W'(COPY_ARGS - 1)) begin
              copy_v_o   <= 1'b1;
              copy_src_o <= arg_q[8*ARG_BYTES-1 -: 24];
              copy_len_o <= arg_q[8*ARG_BYTES-25 -: 8];
              copy_dst_o <= {arg_q[15:0], in_data_i};
              state_q    <= PS_IDLE;
            end else begin
              arg_q <= {arg_q[8*ARG_BYTES-9:0], in_data_i};
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= PS_IDLE;
        endcase
      end
    end
  end

  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  assert_wr_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_v_o |=> !wr_v_o);
  assert_copy_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_v_o |=> !copy_v_o);
  assert_one_event_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_v_o, copy_v_o}));
endmodule

// File: rtl/vidcmd_bank.sv
module vidcmd_bank
  import vidcmd_pkg::*;
#(
  parameter int NUM_REGS = 48
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_v_i,
  input  logic [7:0]            wr_addr_i,
  input  logic [7:0]            wr_data_i,
  output logic [NUM_REGS*8-1:0] live_o,
  output logic                  locked_o,
  output logic                  commit_o
);
  logic lock_hit, do_lock, do_unlock;

  assign lock_hit  = wr_v_i && (wr_addr_i == LOCK_REG);
  assign do_lock   = lock_hit && (wr_data_i == LOCK_ON);
  assign do_unlock = lock_hit && (wr_data_i == LOCK_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_o <= 1'b0;
      commit_o <= 1'b0;
    end else begin
      commit_o <= do_unlock;
      if (do_lock)        locked_o <= 1'b1;
      else if (do_unlock) locked_o <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic       hit;
    logic [7:0] shadow_q;
    assign hit = wr_v_i && (wr_addr_i == 8'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q          <= '0;
        live_o[8*i +: 8]  <= '0;
      end else begin
        if (hit) shadow_q <= wr_data_i;
        if (do_unlock)             live_o[8*i +: 8] <= shadow_q;
        else if (hit && !locked_o) live_o[8*i +: 8] <= wr_data_i;
      end
    end
  end

  assert_locked_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && !do_unlock) |=> $stable(live_o));
  assert_commit_unlocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> !locked_o);
  assert_commit_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);
  assert_lock_takes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_lock |=> locked_o);
endmodule

// File: rtl/vidcmd_fields.sv
module vidcmd_fields
  import vidcmd_pkg::*;
#(
  parameter int NUM_REGS = 48
) (
  input  logic [NUM_REGS*8-1:0] live_i,
  output logic [7:0]            depth_o,
  output logic [7:0]            blank_o,
  output logic [23:0]           base16_o,
  output logic [23:0]           base8_o,
  output logic [15:0]           hpix_o,
  output logic [15:0]           vpix_o,
  output logic [15:0]           pclk_o
);
  assign depth_o  = live_i[8*REG_DEPTH +: 8];
  assign blank_o  = live_i[8*REG_BLANK +: 8];
  // lowest address is most significant
  assign base16_o = {live_i[8*REG_BASE16 +: 8], live_i[8*(REG_BASE16+1) +: 8],
                     live_i[8*(REG_BASE16+2) +: 8]};
  assign base8_o  = {live_i[8*REG_BASE8 +: 8], live_i[8*(REG_BASE8+1) +: 8],
                     live_i[8*(REG_BASE8+2) +: 8]};
  assign hpix_o   = {live_i[8*REG_HPIX +: 8], live_i[8*(REG_HPIX+1) +: 8]};
  assign vpix_o   = {live_i[8*REG_VPIX +: 8], live_i[8*(REG_VPIX+1) +: 8]};
  // pixel clock: low byte first
  assign pclk_o   = {live_i[8*(REG_PCLK+1) +: 8], live_i[8*REG_PCLK +: 8]};
endmodule

// File: rtl/vidcmd_top.sv
module vidcmd_top
  import vidcmd_pkg::*;
#(
  parameter int NUM_REGS = 48
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  input  logic [7:0]            in_data_i,
  output logic                  in_ready_o,
  output logic [NUM_REGS*8-1:0] live_o,
  output logic [7:0]            depth_o,
  output logic [7:0]            blank_o,
  output logic [23:0]           base16_o,
  output logic [23:0]           base8_o,
  output logic [15:0]           hpix_o,
  output logic [15:0]           vpix_o,
  output logic [15:0]           pclk_o,
  output logic                  locked_o,
  output logic                  commit_o,
  output logic                  copy_valid_o,
  output logic [23:0]           copy_src_o,
  output logic [7:0]            copy_len_o,
  output logic [23:0]           copy_dst_o,
  output logic                  err_o
);
  logic       wr_v;
  logic [7:0] wr_addr, wr_data;

  assign in_ready_o = 1'b1;

  vidcmd_parser u_parser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .wr_v_o     (wr_v),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .copy_v_o   (copy_valid_o),
    .copy_src_o (copy_src_o),
    .copy_len_o (copy_len_o),
    .copy_dst_o (copy_dst_o),
    .err_o      (err_o)
  );

  vidcmd_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_v_i    (wr_v),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .live_o    (live_o),
    .locked_o  (locked_o),
    .commit_o  (commit_o)
  );

  vidcmd_fields #(.NUM_REGS(NUM_REGS)) u_fields (
    .live_i   (live_o),
    .depth_o  (depth_o),
    .blank_o  (blank_o),
    .base16_o (base16_o),
    .base8_o  (base8_o),
    .hpix_o   (hpix_o),
    .vpix_o   (vpix_o),
    .pclk_o   (pclk_o)
  );

  assert_copy_keeps_bank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_valid_o |=> $stable(live_o));
  assert_ready_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> in_ready_o);
endmodule

// File: tb/sim_vidcmd_top.sv
module sim_vidcmd_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 48;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              in_valid = 1'b0;
  logic [7:0]        in_data = '0;
  logic              in_ready;
  logic [NREG*8-1:0] live;
  logic [7:0]        depth, blank, copy_len;
  logic [23:0]       base16, base8, copy_src, copy_dst;
  logic [15:0]       hpix, vpix, pclk;
  logic              locked, commit, copy_valid, err;

  int checks = 0;
  int errors = 0;
  logic [56:0] expq[$];  // {kind(1=copy), src, len, dst}

  always #(CLK_PERIOD/2) clk = ~clk;

  vidcmd_top #(.NUM_REGS(NREG)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .live_o(live), .depth_o(depth), .blank_o(blank),
    .base16_o(base16), .base8_o(base8), .hpix_o(hpix), .vpix_o(vpix),
    .pclk_o(pclk), .locked_o(locked), .commit_o(commit),
    .copy_valid_o(copy_valid), .copy_src_o(copy_src), .copy_len_o(copy_len),
    .copy_dst_o(copy_dst), .err_o(err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    put(8'hAF); put(8'h20); put(a); put(d);
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_ni = 1'b1;
  endtask

  // monitor: compare events as they appear
  always @(negedge clk) begin
    if (rst_ni && commit) begin
      checks++;
      if (expq.size() == 0 || expq[0][56] !== 1'b0) begin
        errors++;
        $display("FAIL R4 act=commit exp=%s", expq.size() == 0 ? "none" : "copy");
      end else void'(expq.pop_front());
    end
    if (rst_ni && copy_valid) begin
      checks++;
      if (expq.size() == 0 || expq[0] !== {1'b1, copy_src, copy_len, copy_dst}) begin
        errors++;
        $display("FAIL R8 act=%h exp=%h", {1'b1, copy_src, copy_len, copy_dst},
                 expq.size() == 0 ? 57'h0 : expq[0]);
      end else void'(expq.pop_front());
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [NREG*8-1:0] snap;
    do_reset();
    // R1 reset state
    check("R1 live", 64'(live == '0), 64'd1);
    check("R1 locked", 64'(locked), 64'd0);
    check("R1 err", 64'(err), 64'd0);
    check("R1 strobes", 64'({commit, copy_valid}), 64'd0);
    check("R12 ready", 64'(in_ready), 64'd1);

    // R2 / R7 unlocked direct writes
    wreg(8'h00, 8'h01);
    wreg(8'h1F, 8'h05);
    settle();
    check("R2 R7 depth", 64'(depth), 64'h01);
    check("R7 blank", 64'(blank), 64'h05);

    // R3 lock, then writes held in shadow
    wreg(8'hFF, 8'h00);
    wreg(8'h20, 8'h12); wreg(8'h21, 8'h34); wreg(8'h22, 8'h56);
    wreg(8'h26, 8'hAB); wreg(8'h27, 8'hCD); wreg(8'h28, 8'hEF);
    wreg(8'h0F, 8'h05); wreg(8'h10, 8'h00);
    wreg(8'h17, 8'h03); wreg(8'h18, 8'h20);
    wreg(8'h1B, 8'h34); wreg(8'h1C, 8'h12);
    wreg(8'h00, 8'h00);
    settle();
    check("R3 locked", 64'(locked), 64'd1);
    check("R3 base16 held", 64'(base16), 64'h0);
    check("R3 depth held", 64'(depth), 64'h01);

    // R4 unlock commits
    expq.push_back({1'b0, 56'h0});
    wreg(8'hFF, 8'hFF);
    settle();
    check("R4 unlocked", 64'(locked), 64'd0);
    check("R5 base16", 64'(base16), 64'h123456);
    check("R5 base8", 64'(base8), 64'hABCDEF);
    check("R6 hpix", 64'(hpix), 64'h0500);
    check("R6 vpix", 64'(vpix), 64'h0320);
    check("R6 pclk", 64'(pclk), 64'h1234);
    check("R4 depth", 64'(depth), 64'h00);
    check("R4 commit low", 64'(commit), 64'd0);

    // R8 copy command
    snap = live;
    expq.push_back({1'b1, 24'h010203, 8'h10, 24'h040506});
    put(8'hAF); put(8'h6A); put(8'h01); put(8'h02); put(8'h03);
    put(8'h10); put(8'h04); put(8'h05); put(8'h06);
    settle();
    check("R8 bank kept", 64'(live == snap), 64'd1);
    check("R8 copy low", 64'(copy_valid), 64'd0);

    // R9 lone escape then normal command
    put(8'hAF);
    settle();
    check("R9 no err", 64'(err), 64'd0);
    put(8'hAF); put(8'h20); put(8'h00); put(8'h07);
    settle();
    check("R9 depth", 64'(depth), 64'h07);
    check("R9 err clear", 64'(err), 64'd0);

    // R11 out-of-range address
    snap = live;
    wreg(8'h30, 8'h99);
    wreg(8'hFE, 8'h77);
    settle();
    check("R11 bank kept", 64'(live == snap), 64'd1);

    // R10 unknown operation then resync
    put(8'hAF); put(8'h55);
    settle();
    check("R10 err op", 64'(err), 64'd1);
    wreg(8'h1F, 8'h09);
    settle();
    check("R10 resync", 64'(blank), 64'h09);
    check("R10 sticky", 64'(err), 64'd1);

    // R10 stray byte after fresh reset
    do_reset();
    check("R1 err after reset", 64'(err), 64'd0);
    put(8'h11);
    settle();
    check("R10 err stray", 64'(err), 64'd1);
    wreg(8'h00, 8'h03);
    settle();
    check("R10 stray resync", 64'(depth), 64'h03);

    repeat (4) @(posedge clk);
    #1;
    check("R4 R8 queue empty", 64'(expq.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule